// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This block takes packets arriving as a byte stream and stores them in host memory. It walks a ring of descriptors that the host has set up, and can spread one packet across several chained buffers. Each descriptor is two 32-bit words. The first word carries flags and a buffer length. The second word carries the byte address of the buffer, which must be word aligned. Descriptors sit 8 bytes apart.

The host programs two registers: the ring base and the pointer to the descriptor the engine will use next. The host hands a descriptor to the engine by setting its ownership flag. The engine writes the result back into each status word it consumed, then raises a one-cycle interrupt. Memory is reached through a simple word master port. A request stays up, with its address, data and byte enables held, until a cycle in which `mem_ready` is high. Read data is taken in that same cycle.

Top module: `rx_ring_scatter`

## Requirements
- R1: Descriptor word 0 is at the descriptor address and word 1, the buffer address, is at the descriptor address plus 4. In word 0, bit 31 means the engine owns it, bit 30 means wrap, bit 27 means the packet continues, and bits 12:0 hold the buffer length.
- R2: The descriptor after the current one is at the ring base when the current one has its wrap bit set. Otherwise it is at the current address plus 8.
- R3: Offset 0x4 holds the ring base and offset 0x8 holds the current descriptor pointer. Both can be read and written. Any other offset reads zero and ignores writes.
- R4: While the ring base is zero, an arriving packet is consumed, memory is not accessed, and no interrupt is raised.
- R5: If the descriptor at the current pointer is not owned, the packet is consumed and dropped. Nothing is written, there is no interrupt, and the pointer does not move.
- R6: Each buffer receives the smaller of its length and the bytes of the packet still unstored. Byte k of a buffer lands in lane k mod 4 (bits 8*lane+7 down to 8*lane) of the word at the buffer address plus 4*(k div 4). Lanes that were not written keep their old value.
- R7: The descriptor that takes the final byte of a packet gets status word equal to the bytes stored in it plus 4, with every flag clear. This also holds when the final byte exactly fills the buffer.
- R8: When a buffer fills before the packet ends, the engine reads word 0 of the next descriptor. If that descriptor is owned, the status becomes 0x08000000 OR'd with the stored count. If it is not owned, the status is the count alone, and the rest of the packet is consumed and discarded.
- R9: Status words of descriptors after the first are written as each one is consumed. The first descriptor's status is the last write of the packet. A single one-cycle interrupt follows it.
- R10: Only the first 8192 bytes of a packet are stored. Any later bytes are consumed and discarded.
- R11: The current pointer moves past every consumed descriptor, including the last one. After a stop caused by an unowned descriptor, it points at that unowned descriptor.
- R12: A memory request holds its address until accepted. The first byte of the next packet is not accepted before the interrupt of the previous packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte ends the packet |
| in_ready | output | 1 | Engine takes the byte this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request accepted this cycle |
| irq | output | 1 | One-cycle packet-stored pulse |

## Verification
Two events can land on the same byte: the current buffer filling up, and the packet ending. The engine must treat that byte as the end of the packet. It writes length plus four and does not read the next descriptor. The bench provokes this by sending a packet exactly as long as the buffer, with an owned descriptor following it. It then checks that the following descriptor is untouched and that the status is the buffer length plus four.

A second collision is the interrupt cycle meeting the first byte of a new packet. The bench sends packets back to back with no gap between them. It checks that each packet lands in its own descriptor, that two interrupts are seen, and that the last write before each interrupt went to the first descriptor of that packet.

// File: rtl/rx_ring_scatter.sv
module rx_ring_scatter #(
  parameter int MAX_PKT = 8192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  output logic        irq
);
  localparam int TW = $clog2(MAX_PKT + 1);
  localparam logic [TW-1:0] TOT_LAST = TW'(MAX_PKT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_FILL, S_WRD, S_LNK, S_WST, S_WFS, S_IRQ, S_DRAIN
  } st_t;

  st_t         st;
  logic [31:0] start_r, cur_r, buf_r, waddr_r, wdat_r, stat_r, fs_r, first_addr_r;
  logic [3:0]  be_r;
  logic [12:0] len_r, nlen_r, cnt_r;
  logic [TW-1:0] tot_r;
  logic        wrap_r, nwrap_r, owned_r, last_r, first_r, endp_r, fullp_r, tail_r;
  logic [31:0] nxt;
  logic        take, fin, full;

  assign nxt      = wrap_r ? start_r : cur_r + 32'd8;
  assign in_ready = (st == S_DRAIN) || (st == S_FILL && cnt_r != len_r);
  assign take     = in_valid && in_ready;
  assign fin      = in_last || tot_r == TOT_LAST;
  assign full     = (cnt_r + 13'd1) == len_r;
  assign irq      = (st == S_IRQ);

  always_comb begin
    case (reg_addr)
      4'h4:    reg_rdata = start_r;
      4'h8:    reg_rdata = cur_r;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 32'd0;
    mem_wdata = 32'd0;
    mem_be    = 4'h0;
    case (st)
      S_RD0: begin mem_req = 1'b1; mem_addr = cur_r; end
      S_RD1: begin mem_req = 1'b1; mem_addr = cur_r + 32'd4; end
      S_LNK: begin mem_req = 1'b1; mem_addr = nxt; end
      S_WRD: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = waddr_r; mem_wdata = wdat_r; mem_be = be_r;
      end
      S_WST: begin
        mem_req = !first_r; mem_we = !first_r; mem_addr = cur_r; mem_wdata = stat_r;
        mem_be = first_r ? 4'h0 : 4'hf;
      end
      S_WFS: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = first_addr_r; mem_wdata = fs_r; mem_be = 4'hf;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      start_r <= '0; cur_r <= '0; buf_r <= '0; waddr_r <= '0; wdat_r <= '0;
      stat_r <= '0; fs_r <= '0; first_addr_r <= '0; be_r <= '0;
      len_r <= '0; nlen_r <= '0; cnt_r <= '0; tot_r <= '0;
      wrap_r <= 1'b0; nwrap_r <= 1'b0; owned_r <= 1'b0; last_r <= 1'b0;
      first_r <= 1'b0; endp_r <= 1'b0; fullp_r <= 1'b0; tail_r <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 4'h4) start_r <= reg_wdata;
      if (reg_wr && reg_addr == 4'h8) cur_r <= reg_wdata;
      case (st)
        S_IDLE:
          if (in_valid) st <= (start_r == 32'd0) ? S_DRAIN : S_RD0;
        S_RD0:
          if (mem_ready) begin
            if (!mem_rdata[31]) st <= S_DRAIN;
            else begin
              wrap_r <= mem_rdata[30];
              len_r <= mem_rdata[12:0];
              first_addr_r <= cur_r;
              first_r <= 1'b1;
              tot_r <= '0;
              tail_r <= 1'b0;
              st <= S_RD1;
            end
          end
        S_RD1:
          if (mem_ready) begin
            buf_r <= mem_rdata;
            cnt_r <= '0;
            be_r <= '0;
            endp_r <= 1'b0;
            fullp_r <= 1'b0;
            st <= S_FILL;
          end
        S_FILL:
          if (cnt_r == len_r) st <= S_LNK;
          else if (take) begin
            wdat_r[{cnt_r[1:0], 3'b000} +: 8] <= in_data;
            be_r[cnt_r[1:0]] <= 1'b1;
            if (cnt_r[1:0] == 2'd0) waddr_r <= buf_r + {19'd0, cnt_r[12:2], 2'b00};
            cnt_r <= cnt_r + 13'd1;
            tot_r <= tot_r + 1'b1;
            endp_r <= fin;
            fullp_r <= full;
            if (!in_last && tot_r == TOT_LAST) tail_r <= 1'b1;
            if (cnt_r[1:0] == 2'd3 || fin || full) st <= S_WRD;
          end
        S_WRD:
          if (mem_ready) begin
            be_r <= '0;
            if (endp_r) begin
              stat_r <= {19'd0, cnt_r} + 32'd4;
              last_r <= 1'b1;
              st <= S_WST;
            end else if (fullp_r) st <= S_LNK;
            else st <= S_FILL;
          end
        S_LNK:
          if (mem_ready) begin
            owned_r <= mem_rdata[31];
            nwrap_r <= mem_rdata[30];
            nlen_r <= mem_rdata[12:0];
            stat_r <= {4'd0, mem_rdata[31], 27'd0} | {19'd0, cnt_r};
            last_r <= 1'b0;
            st <= S_WST;
          end
        S_WST:
          if (first_r || mem_ready) begin
            if (first_r) fs_r <= stat_r;
            cur_r <= nxt;
            if (last_r || !owned_r) begin
              if (!last_r) tail_r <= 1'b1;
              st <= S_WFS;
            end else begin
              wrap_r <= nwrap_r;
              len_r <= nlen_r;
              first_r <= 1'b0;
              st <= S_RD1;
            end
          end
        S_WFS:
          if (mem_ready) st <= S_IRQ;
        S_IRQ:
          st <= tail_r ? S_DRAIN : S_IDLE;
        S_DRAIN:
          if (take && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r12_no_take_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !in_ready);
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r9_irq_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WFS && mem_ready) |=> irq);
  a_r4_zero_base_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && in_valid && start_r == 32'd0) |=> (st == S_DRAIN && !mem_req));
  a_r5_unowned_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD0 && mem_ready && !mem_rdata[31]) |=> (st == S_DRAIN && !mem_req));
  a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  a_r6_write_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_be != 4'h0);
endmodule

// File: tb/rx_ring_scatter_test.sv
module rx_ring_scatter_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = 8'd0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic mem_req, mem_we, mem_ready = 1'b0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  rx_ring_scatter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .irq(irq));

  logic [31:0] mem [0:4095];
  logic [31:0] exp_mem [0:4095];
  logic [7:0]  pkt [0:8399];
  logic [31:0] estart = 0, ecur = 0, last_wr = 0, irq_wr = 0;
  int irq_cnt = 0, n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  assign mem_rdata = mem[mem_addr[13:2]];

  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      last_wr <= mem_addr;
    end
    if (irq) begin
      irq_cnt <= irq_cnt + 1;
      irq_wr <= last_wr;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 190000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a[13:2]] = v;
    exp_mem[a[13:2]] = v;
  endtask

  function automatic logic [31:0] dw0(input bit own, input bit wrap, input int len);
    return {own, wrap, 17'd0, 13'(len)};
  endfunction

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 4'h4) estart = d;
    if (a == 4'h8) ecur = d;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fill_pkt(input int n);
    for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
  endtask

  task automatic model_pkt(input int n, inout int eirq, inout logic [31:0] efirst);
    logic [31:0] d, w0, nw, bufa, st, nxt, fs, a;
    int rem, pos, cp, idx;
    bit go;
    if (estart == 0) return;
    if (n > 8192) n = 8192;
    d = ecur;
    w0 = exp_mem[d[13:2]];
    if (!w0[31]) return;
    efirst = d; rem = n; pos = 0; idx = 0; fs = 0; go = 1;
    while (go) begin
      bufa = exp_mem[(d + 4) >> 2];
      cp = (int'(w0[12:0]) < rem) ? int'(w0[12:0]) : rem;
      for (int k = 0; k < cp; k++) begin
        a = bufa + k;
        exp_mem[a[13:2]][8*a[1:0] +: 8] = pkt[pos + k];
      end
      pos += cp; rem -= cp;
      nxt = w0[30] ? estart : d + 8;
      nw = 0;
      if (rem == 0) st = cp + 4;
      else begin
        nw = exp_mem[nxt[13:2]];
        st = (nw[31] ? 32'h0800_0000 : 32'd0) | cp;
      end
      if (idx != 0) exp_mem[d[13:2]] = st; else fs = st;
      ecur = nxt;
      if (rem == 0 || !nw[31]) go = 0;
      else begin w0 = nw; d = nxt; idx++; end
    end
    exp_mem[efirst[13:2]] = fs;
    eirq++;
  endtask

  task automatic send_pkt(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3) == 0) begin
        in_valid = 1'b0;
        repeat (1 + $urandom % 2) @(negedge clk);
      end
      in_valid = 1'b1; in_data = pkt[i]; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic verify(input string req, input int irq0, input int eirq, input logic [31:0] efirst);
    int bad, first_bad;
    logic [31:0] cur;
    repeat (60) @(negedge clk);
    bad = 0; first_bad = -1;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    if (first_bad < 0) check(1, req, "memory image", 0, 0);
    else check(0, req, $sformatf("memory word at %h", first_bad * 4),
               mem[first_bad], exp_mem[first_bad]);
    for (int i = 0; i < 4096; i++) exp_mem[i] = mem[i];
    reg_read(4'h8, cur);
    check(cur === ecur, "R11", "current pointer", cur, ecur);
    check(irq_cnt - irq0 == eirq, "R9", "interrupt count", irq_cnt - irq0, eirq);
    if (eirq > 0) check(irq_wr === efirst, "R9", "last write before interrupt", irq_wr, efirst);
  endtask

  task automatic run_pkt(input string req, input int n, input bit gaps);
    int irq0, eirq;
    logic [31:0] efirst;
    irq0 = irq_cnt; eirq = 0; efirst = 0;
    fill_pkt(n);
    model_pkt(n, eirq, efirst);
    send_pkt(n, gaps);
    verify(req, irq0, eirq, efirst);
  endtask

  initial begin
    logic [31:0] v;
    int irq0, eirq;
    logic [31:0] efirst;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4096; i++) begin mem[i] = 0; exp_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready && !irq && !mem_req, "R12", "idle outputs after reset",
          {29'd0, in_ready, irq, mem_req}, 0);
    reg_read(4'h4, v); check(v == 0, "R3", "base after reset", v, 0);

    reg_write(4'h4, 32'h40); reg_write(4'h8, 32'h88); reg_write(4'hC, 32'hdead_beef);
    reg_read(4'h4, v); check(v == 32'h40, "R3", "base readback", v, 32'h40);
    reg_read(4'h8, v); check(v == 32'h88, "R3", "pointer readback", v, 32'h88);
    reg_read(4'hC, v); check(v == 0, "R3", "unused offset", v, 0);

    // R4: zero base
    reg_write(4'h4, 32'h0); reg_write(4'h8, 32'h40);
    put(32'h40, dw0(1, 0, 64)); put(32'h44, 32'h400);
    run_pkt("R4", 10, 1);
    // R1 R7: single descriptor, partial word
    reg_write(4'h4, 32'h40);
    put(32'h48, dw0(0, 0, 8));
    run_pkt("R7", 21, 1);
    // R7: buffer full and packet end on the same byte
    put(32'h48, dw0(1, 0, 12)); put(32'h4C, 32'h500);
    put(32'h50, dw0(1, 0, 32)); put(32'h54, 32'h5C0);
    run_pkt("R7", 12, 0);
    // R8: chain with odd and zero lengths
    put(32'h50, dw0(1, 0, 8));  put(32'h54, 32'h600);
    put(32'h58, dw0(1, 0, 5));  put(32'h5C, 32'h610);
    put(32'h60, dw0(1, 0, 0));  put(32'h64, 32'h620);
    put(32'h68, dw0(1, 0, 16)); put(32'h6C, 32'h630);
    put(32'h70, dw0(0, 0, 4));
    run_pkt("R8", 25, 1);
    // R8 R11: next not owned, tail discarded, then the next packet
    put(32'h70, dw0(1, 0, 6)); put(32'h74, 32'h700);
    put(32'h78, dw0(0, 0, 40)); put(32'h7C, 32'h740);
    run_pkt("R8", 15, 1);
    put(32'h78, dw0(1, 0, 40)); put(32'h80, dw0(0, 0, 4));
    run_pkt("R11", 9, 1);
    // R5: first descriptor not owned
    run_pkt("R5", 7, 0);
    // R2: wrap back to base
    put(32'h80, dw0(1, 1, 4)); put(32'h84, 32'h780);
    put(32'h40, dw0(1, 0, 20)); put(32'h44, 32'h790);
    put(32'h48, dw0(0, 0, 4));
    run_pkt("R2", 10, 1);
    // R12: two packets back to back
    put(32'h48, dw0(1, 0, 16)); put(32'h4C, 32'h800);
    put(32'h50, dw0(1, 0, 16)); put(32'h54, 32'h840);
    put(32'h58, dw0(0, 0, 4));
    irq0 = irq_cnt; eirq = 0; efirst = 0;
    fill_pkt(9);
    model_pkt(5, eirq, efirst);
    model_pkt(9, eirq, efirst);
    send_pkt(5, 0);
    send_pkt(9, 0);
    verify("R12", irq0, eirq, efirst);
    // R10: truncation
    reg_write(4'h8, 32'h40);
    put(32'h40, dw0(1, 0, 4096)); put(32'h44, 32'h1000);
    put(32'h48, dw0(1, 0, 4100)); put(32'h4C, 32'h2000);
    put(32'h50, dw0(0, 0, 4));
    run_pkt("R10", 8300, 0);
    // R6: random rings
    reg_write(4'h4, 32'h100); reg_write(4'h8, 32'h100);
    for (int p = 0; p < 30; p++) begin
      for (int i = 0; i < 8; i++) begin
        put(32'h100 + 8 * i, dw0(($urandom % 8) != 0, i == 7, $urandom % 49));
        put(32'h104 + 8 * i, 32'h800 + 64 * i);
      end
      run_pkt("R6", 1 + $urandom % 100, 1);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule